// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a computer-operating-properly watchdog. It counts ticks of one of two clock sources: a slow low-power tick with a nominal 1 kHz rate, or a bus tick. If the chosen number of ticks passes with no valid service, it raises a one-cycle reset request toward the system reset controller. Software keeps the system alive with a two-write key sequence on the service port. The rate, or a disable, is set once after reset through a small configuration port.

When the slow tick drives the count, the count is cleared and held while the chip is in low-power stop or debug. Counting restarts from zero when the chip leaves either state. A long sleep therefore never produces a reset. Software has to service from a periodic interrupt whose period is below the timeout.

Top module: `cop_watchdog`

## Requirements
- R1: The timeout-select field (`cfg_wdata[1:0]`) gives the count. With the slow tick, 2'b01 gives 2^5 ticks, 2'b10 gives 2^8 ticks and 2'b11 gives 2^10 ticks. The reset request rises in the clock cycle after the tick that completes the count.
- R2: With `cfg_wdata[2]` = 0 the slow tick advances the count. With `cfg_wdata[2]` = 1 the bus tick advances it, and the counts become 2^13, 2^16 and 2^18. The tick that is not selected has no effect.
- R3: The first configuration write after reset takes effect, and every later write is ignored. Until that first write the block runs with select 2'b11 on the slow tick.
- R4: A service write of 0x55 followed by a service write of 0xAA restarts the count from zero.
- R5: A 0xAA that is not the next service write after 0x55 does not service. Any other value written between the two keys cancels the sequence.
- R6: With the slow tick selected, stop mode clears the count and holds it at zero. No reset request is raised however many ticks arrive during stop. After exit, a full timeout is needed.
- R7: With the slow tick selected, debug mode clears and holds the count in the same way as stop mode.
- R8: The reset request lasts exactly one cycle. The count restarts from zero after it, so the next request needs a full timeout.
- R9: Timeout select 2'b00 disables the watchdog: the count stays at zero and no request is raised.
- R10: After reset the reset request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | [1:0] timeout select, [2] bus-tick select |
| svc_wr | input | 1 | Service write strobe |
| svc_wdata | input | 8 | Service write value |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| bus_tick | input | 1 | One-cycle pulse per bus-clock period |
| stop_mode | input | 1 | Chip is in low-power stop |
| debug_mode | input | 1 | Chip is halted in debug |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench counts every timeout exactly, to the tick, for each select value and both tick sources. A one-off compare would fire a tick early or late, and a swapped source would never fire. It services in the middle of a count, and sends a broken key pair and a lone 0xAA. A checker that accepted keys out of order would suppress a reset that is owed. It sleeps in stop and in debug far longer than a timeout and then counts a full period after exit. A design that only paused the count would fire early after wake-up, and one that kept counting would fire during sleep. It also writes the configuration twice, to catch a register that is not write-once, and counts across back-to-back timeouts to catch a count that does not restart.

// File: rtl/cop_pkg.sv
`timescale 1ns/1ps
package cop_pkg;

  typedef struct packed {
    logic       use_bus;
    logic [1:0] tsel;
  } cop_cfg_t;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  // log2 of the timeout length in ticks of the selected source
  function automatic int unsigned timeout_log(input logic [1:0] tsel,
                                              input logic       use_bus,
                                              input int unsigned l1,
                                              input int unsigned l2,
                                              input int unsigned l3,
                                              input int unsigned bus_shift);
    int unsigned base;
    case (tsel)
      2'b01:   base = l1;
      2'b10:   base = l2;
      default: base = l3;
    endcase
    return use_bus ? base + bus_shift : base;
  endfunction

endpackage

// File: rtl/cop_cfg_reg.sv
`timescale 1ns/1ps
module cop_cfg_reg
  import cop_pkg::*;
#(
  parameter logic [1:0] RST_TSEL = 2'b11,
  parameter logic       RST_BUS  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  output cop_cfg_t   cfg_o
);

  cop_cfg_t cfg_q;
  logic     locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{use_bus: RST_BUS, tsel: RST_TSEL};
      locked_q <= 1'b0;
    end else if (wr_i && !locked_q) begin
      cfg_q    <= '{use_bus: wdata_i[2], tsel: wdata_i[1:0]};
      locked_q <= 1'b1;
    end
  end

  assign cfg_o = cfg_q;

  // R3: once locked, a write leaves the configuration untouched
  a_r3_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_i) |=> $stable(cfg_q));

endmodule

// File: rtl/cop_key_check.sv
`timescale 1ns/1ps
module cop_key_check
  import cop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       svc_o
);

  logic armed_q;

  assign svc_o = wr_i && (wdata_i == KEY_SECOND) && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    armed_q <= 1'b0;
    else if (wr_i) armed_q <= (wdata_i == KEY_FIRST);
  end

  // R5: a service consumes the first key, so two services never come back to back
  a_r5_no_double_service: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |=> !svc_o);

endmodule

// File: rtl/cop_counter.sv
`timescale 1ns/1ps
module cop_counter
  import cop_pkg::*;
#(
  parameter int unsigned L1 = 5,
  parameter int unsigned L2 = 8,
  parameter int unsigned L3 = 10,
  parameter int unsigned BS = 8,
  localparam int unsigned CW = L3 + BS
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cop_cfg_t cfg_i,
  input  logic     slow_tick_i,
  input  logic     bus_tick_i,
  input  logic     stop_i,
  input  logic     debug_i,
  input  logic     svc_i,
  output logic     rst_req_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;
  logic          en, tick, hold, adv, expire;
  logic          rst_req_q;

  always_comb begin
    last_cnt = CW'((64'd1 << timeout_log(cfg_i.tsel, cfg_i.use_bus, L1, L2, L3, BS)) - 64'd1);
  end

  assign en     = (cfg_i.tsel != 2'b00);
  assign tick   = cfg_i.use_bus ? bus_tick_i : slow_tick_i;
  assign hold   = !cfg_i.use_bus && (stop_i || debug_i);
  assign adv    = en && !hold && tick && !svc_i;
  assign expire = adv && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= expire;
      if (!en || hold || svc_i || expire) cnt_q <= '0;
      else if (adv)                       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_req_o = rst_req_q;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> (cnt_q == '0));
  a_r6_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0) && !rst_req_q);
  a_r4_service_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    svc_i |=> (cnt_q == '0) && !rst_req_q);
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0) && !rst_req_q);

endmodule

// File: rtl/cop_watchdog.sv
`timescale 1ns/1ps
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int unsigned LOG_SHORT = 5,
  parameter int unsigned LOG_MID   = 8,
  parameter int unsigned LOG_LONG  = 10,
  parameter int unsigned BUS_SHIFT = 8,
  parameter logic [1:0]  RST_TSEL  = 2'b11,
  parameter logic        RST_BUS   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_wdata,
  input  logic       svc_wr,
  input  logic [7:0] svc_wdata,
  input  logic       slow_tick,
  input  logic       bus_tick,
  input  logic       stop_mode,
  input  logic       debug_mode,
  output logic       rst_req
);

  cop_cfg_t cfg;
  logic     svc_ok;

  cop_cfg_reg #(.RST_TSEL(RST_TSEL), .RST_BUS(RST_BUS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .wdata_i(cfg_wdata), .cfg_o(cfg)
  );

  cop_key_check u_key (
    .clk(clk), .rst_n(rst_n), .wr_i(svc_wr), .wdata_i(svc_wdata), .svc_o(svc_ok)
  );

  cop_counter #(.L1(LOG_SHORT), .L2(LOG_MID), .L3(LOG_LONG), .BS(BUS_SHIFT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .slow_tick_i(slow_tick),
    .bus_tick_i(bus_tick), .stop_i(stop_mode), .debug_i(debug_mode),
    .svc_i(svc_ok), .rst_req_o(rst_req)
  );

  // R10: output quiet in the first cycle after reset release
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !rst_req);

endmodule

// File: tb/tb_cop_watchdog.sv
`timescale 1ns/1ps
module tb_cop_watchdog;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic       svc_wr = 1'b0;
  logic [7:0] svc_wdata = '0;
  logic       slow_tick = 1'b0;
  logic       bus_tick = 1'b0;
  logic       stop_mode = 1'b0;
  logic       debug_mode = 1'b0;
  logic       rst_req;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int doubles = 0;
  logic prev_req = 1'b0;

  always #5 clk = ~clk;

  cop_watchdog dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .svc_wr(svc_wr), .svc_wdata(svc_wdata), .slow_tick(slow_tick),
    .bus_tick(bus_tick), .stop_mode(stop_mode), .debug_mode(debug_mode),
    .rst_req(rst_req)
  );

  always @(negedge clk) begin
    if (rst_req) pulses++;
    if (rst_req && prev_req) doubles++;
    prev_req <= rst_req;
  end

  // vector table: timeout select, bus select, expected ticks to reset
  localparam int NV = 4;
  localparam logic [1:0] V_TSEL [NV] = '{2'b01, 2'b10, 2'b11, 2'b01};
  localparam logic       V_BUS  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1};
  localparam int         V_N    [NV] = '{32, 256, 1024, 8192};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stop_mode = 1'b0; debug_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
    pulses = 0; doubles = 0;
  endtask

  task automatic write_cfg(input logic [1:0] ts, input logic bus);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = {bus, ts};
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic write_svc(input logic [7:0] d);
    @(negedge clk); svc_wr = 1'b1; svc_wdata = d;
    @(negedge clk); svc_wr = 1'b0;
  endtask

  task automatic ticks(input int n, input logic bus);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bus) bus_tick = 1'b1; else slow_tick = 1'b1;
      @(negedge clk);
      bus_tick = 1'b0; slow_tick = 1'b0;
    end
    settle();
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R10 reset output low", int'(rst_req), 0);

    // table walk: R1 lengths, R2 source select with wrong-source ticks ignored
    for (int v = 0; v < NV; v++) begin
      do_reset();
      write_cfg(V_TSEL[v], V_BUS[v]);
      ticks(40, !V_BUS[v]);
      ticks(V_N[v] - 1, V_BUS[v]);
      chk($sformatf("R1 R2 vec%0d no early reset", v), pulses, 0);
      ticks(1, V_BUS[v]);
      chk($sformatf("R1 R2 vec%0d reset on last tick", v), pulses, 1);
    end

    // R3: default config before any write, bus ticks ignored
    do_reset();
    ticks(50, 1'b1);
    ticks(1023, 1'b0);
    chk("R3 default no early reset", pulses, 0);
    ticks(1, 1'b0);
    chk("R3 default 1024 slow ticks", pulses, 1);

    // R3: second config write ignored
    do_reset();
    write_cfg(2'b01, 1'b0);
    write_cfg(2'b00, 1'b1);
    ticks(31, 1'b0);
    chk("R3 second write ignored early", pulses, 0);
    ticks(1, 1'b0);
    chk("R3 second write ignored fires", pulses, 1);

    // R4: valid service restarts count
    do_reset();
    write_cfg(2'b01, 1'b0);
    ticks(20, 1'b0);
    write_svc(8'h55); write_svc(8'hAA);
    ticks(31, 1'b0);
    chk("R4 service restarts count", pulses, 0);
    ticks(1, 1'b0);
    chk("R4 full timeout after service", pulses, 1);

    // R5: interrupted key pair
    do_reset();
    write_cfg(2'b01, 1'b0);
    ticks(20, 1'b0);
    write_svc(8'h55); write_svc(8'h11); write_svc(8'hAA);
    ticks(12, 1'b0);
    chk("R5 cancelled sequence no service", pulses, 1);

    // R5: lone second key
    do_reset();
    write_cfg(2'b01, 1'b0);
    ticks(20, 1'b0);
    write_svc(8'hAA);
    ticks(12, 1'b0);
    chk("R5 lone 0xAA no service", pulses, 1);

    // R6: stop clears and holds
    do_reset();
    write_cfg(2'b01, 1'b0);
    ticks(20, 1'b0);
    @(negedge clk); stop_mode = 1'b1;
    ticks(200, 1'b0);
    chk("R6 no reset during stop", pulses, 0);
    @(negedge clk); stop_mode = 1'b0;
    ticks(31, 1'b0);
    chk("R6 count from zero after stop", pulses, 0);
    ticks(1, 1'b0);
    chk("R6 full timeout after stop", pulses, 1);

    // R7: debug clears and holds
    do_reset();
    write_cfg(2'b01, 1'b0);
    ticks(25, 1'b0);
    @(negedge clk); debug_mode = 1'b1;
    ticks(100, 1'b0);
    chk("R7 no reset during debug", pulses, 0);
    @(negedge clk); debug_mode = 1'b0;
    ticks(31, 1'b0);
    chk("R7 count from zero after debug", pulses, 0);
    ticks(1, 1'b0);
    chk("R7 full timeout after debug", pulses, 1);

    // R8: single-cycle pulse and restart
    do_reset();
    write_cfg(2'b01, 1'b0);
    ticks(32, 1'b0);
    chk("R8 first pulse", pulses, 1);
    chk("R8 pulse one cycle", doubles, 0);
    ticks(31, 1'b0);
    chk("R8 count restarted", pulses, 1);
    ticks(1, 1'b0);
    chk("R8 second pulse", pulses, 2);
    chk("R8 pulses stay one cycle", doubles, 0);

    // R9: disabled
    do_reset();
    write_cfg(2'b00, 1'b0);
    ticks(1100, 1'b0);
    chk("R9 disabled no reset", pulses, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule